// File: doc/BRIEF.md
# Byte-Loaded Phase Accumulator Synthesizer

This block is the numeric core of a direct digital synthesizer. A host writes a 40-bit configuration over an 8-bit parallel bus, one byte per rising edge of a byte strobe. The first byte is a control byte whose bit 0 requests the 6x reference multiplier. The next four bytes form a 32-bit tuning word, most significant byte first. The bytes collect in a shadow register. They do nothing until a separate commit strobe copies the whole 40 bits into the live register.

On every system clock, a 32-bit phase accumulator adds the live tuning word and wraps modulo 2^32. The output frequency is tuning_word × f_sys / 2^32. At 180 MHz, a word of 0x016C16C1 gives about 1 MHz. The accumulator value is driven out for a downstream lookup table. Its top bit also serves as a square-wave output. The control bit drives the multiplier-enable flag.

The byte strobe and the commit strobe are asynchronous to the system clock. Each one passes through a two-flop synchronizer and a rising-edge detector. A byte-position counter decides which field the next byte fills.

Top module: `dds_tuning_core`

## Requirements
- R1: While rst_ni is low, and after it is released with no commit, phase_o is 0, square_o is 0 and mult_en_o is 0.
- R2: Each rising edge of byte_strobe_i stores data_i into one field. After reset or a commit, the first byte goes to the control field, and bytes 2 to 5 go to tuning-word bits 31:24, 23:16, 15:8 and 7:0 in that order.
- R3: Bytes loaded without a commit do not change the phase step or mult_en_o.
- R4: A rising edge of commit_i copies all 40 shadow bits into the live register. After that, mult_en_o equals bit 0 of the control byte.
- R5: On every clock, phase_o advances by the live tuning word, modulo 2^32.
- R6: square_o always equals bit 31 of phase_o.
- R7: A commit returns the byte position to the control field. After a partial load, the committed word is made of the new fields plus the older shadow contents.
- R8: A sixth byte sent without a commit wraps around and overwrites the control field.
- R9: When a byte edge and a commit edge are detected in the same cycle, the commit includes that byte, and the following byte goes to the control field.
- R10: A byte strobe held high for many clocks stores exactly one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_strobe_i | input | 1 | Asynchronous byte strobe; the rising edge stores data_i |
| commit_i | input | 1 | Asynchronous commit strobe; the rising edge makes the shadow word live |
| data_i | input | 8 | Byte bus |
| phase_o | output | 32 | Phase accumulator value |
| square_o | output | 1 | Accumulator MSB, used as a square wave |
| mult_en_o | output | 1 | Reference multiplier enable (control bit 0) |

## Verification
A byte capture and a commit can land in the same system cycle. When they do, the block must decide whether the last byte takes part in the commit, and where the next byte goes. The bench provokes this by raising both strobes on the same clock edge, so that both synchronizers fire together. It judges the result in two ways. The phase step and the multiplier flag must show the complete word, including the fifth byte. A single byte sent next, followed by a commit, must change only the control field.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int unsigned BUS_W    = 8;
  localparam int unsigned CTRL_W   = 8;
  localparam int unsigned TW_W     = 32;
  localparam int unsigned MULT_BIT = 0;
  localparam int unsigned WORD_W   = CTRL_W + TW_W;
  localparam int unsigned NBYTES   = WORD_W / BUS_W;

  typedef struct packed {
    logic [CTRL_W-1:0] ctrl;
    logic [TW_W-1:0]   tw;
  } cfg_word_t;
endpackage

// File: rtl/dds_edge_sync.sv
module dds_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-1:0], async_i};
  end

  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

  assert_single_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/dds_word_loader.sv
module dds_word_loader #(
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned NBYTES = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      byte_i,
  input  logic [BUS_W-1:0]          data_i,
  input  logic                      commit_i,
  output logic [NBYTES*BUS_W-1:0]   active_o
);
  localparam int unsigned WORD_W = NBYTES * BUS_W;
  localparam int unsigned CNT_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBYTES - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shadow_q, shadow_nxt, active_q;

  // lane 0 (control) sits at the top of the word
  always_comb begin
    shadow_nxt = shadow_q;
    for (int i = 0; i < NBYTES; i++) begin
      if (byte_i && cnt_q == CNT_W'(i))
        shadow_nxt[(NBYTES-1-i)*BUS_W +: BUS_W] = data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      shadow_q <= shadow_nxt;
      if (commit_i) begin
        cnt_q    <= '0;
        active_q <= shadow_nxt;  // coincident byte is included
      end else if (byte_i) begin
        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
    end
  end

  assign active_o = active_q;

  assert_cnt_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  assert_commit_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> cnt_q == '0);
  assert_shadow_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_i |=> $stable(shadow_q));
  assert_active_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(active_q));
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int unsigned PW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] step_i,
  output logic [PW-1:0] phase_o
);
  logic [PW-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= phase_q + step_i;  // wraps mod 2^PW
  end

  assign phase_o = phase_q;

  assert_zero_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i == '0 |=> $stable(phase_q));
endmodule

// File: rtl/dds_tuning_core.sv
module dds_tuning_core
  import dds_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_strobe_i,
  input  logic             commit_i,
  input  logic [BUS_W-1:0] data_i,
  output logic [TW_W-1:0]  phase_o,
  output logic             square_o,
  output logic             mult_en_o
);
  logic        byte_rise, commit_rise;
  logic [WORD_W-1:0] active_bits;
  cfg_word_t   active;

  dds_edge_sync #(.STAGES(SYNC_STAGES)) i_sync_byte (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(byte_strobe_i), .rise_o(byte_rise));

  dds_edge_sync #(.STAGES(SYNC_STAGES)) i_sync_commit (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(commit_i), .rise_o(commit_rise));

  dds_word_loader #(.BUS_W(BUS_W), .NBYTES(NBYTES)) i_loader (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_i(byte_rise), .data_i(data_i),
    .commit_i(commit_rise), .active_o(active_bits));

  assign active = cfg_word_t'(active_bits);

  dds_phase_acc #(.PW(TW_W)) i_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(active.tw), .phase_o(phase_o));

  assign square_o  = phase_o[TW_W-1];
  assign mult_en_o = active.ctrl[MULT_BIT];

  assert_mult_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_rise |=> $stable(mult_en_o));
  assert_commit_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_rise |=> !commit_rise);
endmodule

// File: tb/test_dds_tuning_core.sv
`timescale 1ns/1ps
module test_dds_tuning_core;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        byte_strobe_i = 1'b0;
  logic        commit_i = 1'b0;
  logic [7:0]  data_i = '0;
  logic [31:0] phase_o;
  logic        square_o, mult_en_o;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  dds_tuning_core i_dds_tuning_core (
    .clk_i(clk), .rst_ni(rst_ni), .byte_strobe_i(byte_strobe_i), .commit_i(commit_i),
    .data_i(data_i), .phase_o(phase_o), .square_o(square_o), .mult_en_o(mult_en_o));

  // {control, tuning word}
  localparam logic [39:0] VEC [5] = '{
    40'h01_016C16C1, 40'h00_0E38E38E, 40'h01_FFFFFFFF,
    40'h00_00000001, 40'h01_80000000 };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input int hold, input logic with_commit);
    @(negedge clk);
    data_i = b;
    byte_strobe_i = 1'b1;
    if (with_commit) commit_i = 1'b1;
    wait_cycles(hold);
    byte_strobe_i = 1'b0;
    commit_i = 1'b0;
    wait_cycles(4);
  endtask

  task automatic commit();
    @(negedge clk);
    commit_i = 1'b1;
    wait_cycles(4);
    commit_i = 1'b0;
    wait_cycles(4);
  endtask

  task automatic load_word(input logic [39:0] w);
    for (int k = 0; k < 5; k++) send_byte(w[39-8*k -: 8], 4, 1'b0);
  endtask

  task automatic measure_step(output logic [31:0] d);
    logic [31:0] p1;
    @(negedge clk); p1 = phase_o;
    @(negedge clk); d = phase_o - p1;
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic        prev_sq;
    int          sq_ok;

    // R1 reset state
    wait_cycles(3);
    check("R1 phase in reset", phase_o, 32'h0);
    check("R1 mult in reset", {31'h0, mult_en_o}, 32'h0);
    rst_ni = 1'b1;
    wait_cycles(5);
    check("R1 phase idle", phase_o, 32'h0);
    check("R1 square idle", {31'h0, square_o}, 32'h0);

    // R2 R4 R5 vector table
    for (int i = 0; i < 5; i++) begin
      load_word(VEC[i]);
      commit();
      measure_step(d);
      check("R5 step", d, VEC[i][31:0]);
      check("R4 mult", {31'h0, mult_en_o}, {31'h0, VEC[i][32]});
    end

    // R6 square follows MSB; step 0x80000000 flips it every cycle
    sq_ok = 1;
    @(negedge clk); prev_sq = square_o;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (square_o !== phase_o[31] || square_o === prev_sq) sq_ok = 0;
      prev_sq = square_o;
    end
    check("R6 square", sq_ok, 1);

    // R3 shadow has no effect before commit
    load_word(40'h00_12345678);
    measure_step(d);
    check("R3 step unchanged", d, 32'h80000000);
    check("R3 mult unchanged", {31'h0, mult_en_o}, 32'h1);
    commit();
    measure_step(d);
    check("R4 step after commit", d, 32'h12345678);

    // R7 partial load then commit: counter restarts
    send_byte(8'h01, 4, 1'b0);
    send_byte(8'hAB, 4, 1'b0);
    commit();
    measure_step(d);
    check("R7 partial mix", d, 32'hAB345678);
    check("R7 partial mult", {31'h0, mult_en_o}, 32'h1);
    load_word(40'h00_00C0FFEE);
    commit();
    measure_step(d);
    check("R7 reload after partial", d, 32'h00C0FFEE);

    // R8 sixth byte overwrites the control field
    load_word(40'h00_11223344);
    send_byte(8'h01, 4, 1'b0);
    commit();
    measure_step(d);
    check("R8 wrap step", d, 32'h11223344);
    check("R8 wrap mult", {31'h0, mult_en_o}, 32'h1);

    // R9 fifth byte and commit detected in the same cycle
    for (int k = 0; k < 4; k++) send_byte(8'(40'h00_0A0B0C0D >> (32 - 8*k)), 4, 1'b0);
    send_byte(8'h0D, 4, 1'b1);
    measure_step(d);
    check("R9 coincident step", d, 32'h0A0B0C0D);
    check("R9 coincident mult", {31'h0, mult_en_o}, 32'h0);
    send_byte(8'h01, 4, 1'b0);
    commit();
    measure_step(d);
    check("R9 next byte is control step", d, 32'h0A0B0C0D);
    check("R9 next byte is control mult", {31'h0, mult_en_o}, 32'h1);

    // R10 long strobe stores one byte only
    send_byte(8'h00, 30, 1'b0);
    send_byte(8'h00, 30, 1'b0);
    send_byte(8'h00, 30, 1'b0);
    send_byte(8'h07, 30, 1'b0);
    send_byte(8'h00, 30, 1'b0);
    commit();
    measure_step(d);
    check("R10 long strobe step", d, 32'h00000700);

    // R1 reset mid-run
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    check("R1 phase cleared", phase_o, 32'h0);
    check("R1 mult cleared", {31'h0, mult_en_o}, 32'h0);
    rst_ni = 1'b1;
    wait_cycles(4);
    measure_step(d);
    check("R1 step cleared", d, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule